// File: doc/BRIEF.md
# Two-Source Selective Element Pack Unit

This block is a vector permutation stage. It takes two source vectors and the current contents of a destination vector. It copies one element of the first source and one element of the second source into two positions of the destination. Every other destination element is left as it was. A 16-bit control word holds four 4-bit indices: which element to read from each source, and where each one lands. Because each operation places two scattered values without disturbing the rest, gathering N values that sit in N different registers into one vector takes N/2 operations rather than N-1.

The caller presents both sources, the old destination, the control word and a valid strobe on the same cycle. One clock later the merged destination appears, together with a matching valid output. The latency is one registered stage, which is the same as a plain shuffle of the same width. When no strobe arrives, the registered result holds its value.

Top module: `sel_pack_unit`

## Requirements
- R1: While reset is high and on the first cycle after it, `out_valid` is 0 and `dst_new` is all zeros.
- R2: `out_valid` equals the value `in_valid` had on the previous clock edge. Strobes on consecutive cycles each give one result, with no gap.
- R3: Element k of a vector occupies bits [32k+31:32k]. After a strobe, element `ctrl[7:4]` of `dst_new` equals element `ctrl[3:0]` of `src_a`, unless R6 applies.
- R4: After a strobe, element `ctrl[15:12]` of `dst_new` equals element `ctrl[11:8]` of `src_b`.
- R5: After a strobe, every element named by neither `ctrl[7:4]` nor `ctrl[15:12]` equals the same element of `dst_old`.
- R6: When `ctrl[7:4]` equals `ctrl[15:12]`, that element takes the value from `src_b`, and only that one element differs from `dst_old`.
- R7: On a cycle with `in_valid` low, `dst_new` keeps its previous value on the next cycle.
- R8: All 16 values of each 4-bit index are legal, including 0 and 15 in every field at once.
- R9: Feeding each result back as `dst_old`, eight operations gather 16 values, taken from 16 different source vectors, into one vector in index order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| ctrl | input | 16 | Indices: [3:0] source A element, [7:4] its destination, [11:8] source B element, [15:12] its destination |
| src_a | input | 512 | First source vector, 16 elements of 32 bits |
| src_b | input | 512 | Second source vector |
| dst_old | input | 512 | Current destination contents |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| dst_new | output | 512 | Merged destination vector |

## Verification
The hardest case to reach from the ports is a result that can only be right if writes from earlier operations were kept. That happens in a gather chain, where each result goes back in as the next `dst_old` and a single misplaced or clobbered element shows up only in the final vector. The stimulus runs an eight-step chain over sixteen source vectors. Each vector holds its wanted value at a different index and noise everywhere else, so a wrong source index or lost element is visible at the end. Colliding destinations, the extreme index values and idle gaps between back-to-back strobes are driven as directed cases. Random control words are then run back to back.

// File: rtl/selpack_pkg.sv
package selpack_pkg;

  localparam int DEF_N_ELEM = 16;
  localparam int DEF_ELEM_W = 32;

  // Per-element source choice made by the write decoder.
  typedef enum logic [1:0] {
    PICK_OLD = 2'd0,
    PICK_A   = 2'd1,
    PICK_B   = 2'd2
  } pick_e;

endpackage

// File: rtl/pack_elem_sel.sv
module pack_elem_sel #(
  parameter int N_ELEM = 16,
  parameter int ELEM_W = 32,
  localparam int IDX_W = $clog2(N_ELEM),
  localparam int VEC_W = N_ELEM * ELEM_W
) (
  input  logic [VEC_W-1:0]  vec,
  input  logic [IDX_W-1:0]  idx,
  output logic [ELEM_W-1:0] elem
);

  logic [ELEM_W-1:0] lanes [N_ELEM];

  for (genvar g = 0; g < N_ELEM; g++) begin : g_lane
    assign lanes[g] = vec[g*ELEM_W +: ELEM_W];
  end

  always_comb begin
    elem = lanes[idx];
  end

endmodule

// File: rtl/pack_wdec.sv
module pack_wdec
  import selpack_pkg::*;
#(
  parameter int N_ELEM = 16,
  localparam int IDX_W = $clog2(N_ELEM)
) (
  input  logic [IDX_W-1:0] dst_a,
  input  logic [IDX_W-1:0] dst_b,
  output pick_e            pick [N_ELEM]
);

  // The second source has priority on a shared destination.
  for (genvar g = 0; g < N_ELEM; g++) begin : g_dec
    always_comb begin
      if (dst_b == IDX_W'(g))      pick[g] = PICK_B;
      else if (dst_a == IDX_W'(g)) pick[g] = PICK_A;
      else                         pick[g] = PICK_OLD;
    end
  end

endmodule

// File: rtl/pack_merge.sv
module pack_merge
  import selpack_pkg::*;
#(
  parameter int N_ELEM = 16,
  parameter int ELEM_W = 32,
  localparam int VEC_W = N_ELEM * ELEM_W
) (
  input  logic [VEC_W-1:0]  old_vec,
  input  logic [ELEM_W-1:0] elem_a,
  input  logic [ELEM_W-1:0] elem_b,
  input  pick_e             pick [N_ELEM],
  output logic [VEC_W-1:0]  merged
);

  for (genvar g = 0; g < N_ELEM; g++) begin : g_mrg
    always_comb begin
      unique case (pick[g])
        PICK_A:  merged[g*ELEM_W +: ELEM_W] = elem_a;
        PICK_B:  merged[g*ELEM_W +: ELEM_W] = elem_b;
        default: merged[g*ELEM_W +: ELEM_W] = old_vec[g*ELEM_W +: ELEM_W];
      endcase
    end
  end

endmodule

// File: rtl/sel_pack_unit.sv
module sel_pack_unit
  import selpack_pkg::*;
#(
  parameter int N_ELEM = DEF_N_ELEM,
  parameter int ELEM_W = DEF_ELEM_W,
  localparam int IDX_W  = $clog2(N_ELEM),
  localparam int VEC_W  = N_ELEM * ELEM_W,
  localparam int CTRL_W = 4 * IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic [VEC_W-1:0]  src_a,
  input  logic [VEC_W-1:0]  src_b,
  input  logic [VEC_W-1:0]  dst_old,
  output logic              out_valid,
  output logic [VEC_W-1:0]  dst_new
);

  // Control fields, lowest first: A source, A destination, B source, B destination.
  logic [IDX_W-1:0] idx_sa, idx_da, idx_sb, idx_db;
  assign idx_sa = ctrl[0*IDX_W +: IDX_W];
  assign idx_da = ctrl[1*IDX_W +: IDX_W];
  assign idx_sb = ctrl[2*IDX_W +: IDX_W];
  assign idx_db = ctrl[3*IDX_W +: IDX_W];

  logic [ELEM_W-1:0] pick_val_a, pick_val_b;
  pick_e             lane_pick [N_ELEM];
  logic [VEC_W-1:0]  merged;

  pack_elem_sel #(.N_ELEM(N_ELEM), .ELEM_W(ELEM_W)) u_sel_a (
    .vec (src_a),
    .idx (idx_sa),
    .elem(pick_val_a)
  );

  pack_elem_sel #(.N_ELEM(N_ELEM), .ELEM_W(ELEM_W)) u_sel_b (
    .vec (src_b),
    .idx (idx_sb),
    .elem(pick_val_b)
  );

  pack_wdec #(.N_ELEM(N_ELEM)) u_wdec (
    .dst_a(idx_da),
    .dst_b(idx_db),
    .pick (lane_pick)
  );

  pack_merge #(.N_ELEM(N_ELEM), .ELEM_W(ELEM_W)) u_merge (
    .old_vec(dst_old),
    .elem_a (pick_val_a),
    .elem_b (pick_val_b),
    .pick   (lane_pick),
    .merged (merged)
  );

  // Single output stage; the result register loads only on a strobe.
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      dst_new   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) dst_new <= merged;
    end
  end

  // Assertions
  p_lat_on_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_lat_off_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(dst_new));

  for (genvar g = 0; g < N_ELEM; g++) begin : g_chk
    p_place_a_r3: assert property (@(posedge clk) disable iff (rst)
      (in_valid && idx_da == IDX_W'(g) && idx_db != IDX_W'(g))
      |=> dst_new[g*ELEM_W +: ELEM_W] == $past(pick_val_a));

    p_place_b_r4: assert property (@(posedge clk) disable iff (rst)
      (in_valid && idx_db == IDX_W'(g))
      |=> dst_new[g*ELEM_W +: ELEM_W] == $past(pick_val_b));

    p_keep_r5: assert property (@(posedge clk) disable iff (rst)
      (in_valid && idx_da != IDX_W'(g) && idx_db != IDX_W'(g))
      |=> dst_new[g*ELEM_W +: ELEM_W] == $past(dst_old[g*ELEM_W +: ELEM_W]));

    p_collide_r6: assert property (@(posedge clk) disable iff (rst)
      (in_valid && idx_da == IDX_W'(g) && idx_db == IDX_W'(g))
      |=> dst_new[g*ELEM_W +: ELEM_W] == $past(src_b[idx_sb*ELEM_W +: ELEM_W]));
  end

endmodule

// File: tb/sim_sel_pack_unit.sv
module sim_sel_pack_unit;

  localparam int N  = 16;
  localparam int EW = 32;
  localparam int VW = N * EW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [15:0]   ctrl = '0;
  logic [VW-1:0] src_a = '0, src_b = '0, dst_old = '0;
  logic          out_valid;
  logic [VW-1:0] dst_new;

  always #10 clk = ~clk; // 50 MHz

  sel_pack_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .ctrl(ctrl),
    .src_a(src_a), .src_b(src_b), .dst_old(dst_old),
    .out_valid(out_valid), .dst_new(dst_new)
  );

  int n_run = 0;
  int n_fail = 0;
  logic [VW-1:0] exp_q [$];
  string         tag_q [$];
  logic [VW-1:0] last_res = '0;
  bit            done = 0;

  function automatic logic [VW-1:0] rand_vec();
    logic [VW-1:0] v;
    for (int i = 0; i < N; i++) v[i*EW +: EW] = $urandom();
    return v;
  endfunction

  // Expected result built from R3..R6: copy old, place A, then place B last.
  function automatic logic [VW-1:0] model(logic [VW-1:0] a, logic [VW-1:0] b,
                                          logic [VW-1:0] o, logic [15:0] c);
    logic [VW-1:0] r;
    r = o;
    r[c[7:4]*EW +: EW]   = a[c[3:0]*EW +: EW];
    r[c[15:12]*EW +: EW] = b[c[11:8]*EW +: EW];
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [VW-1:0] got, logic [VW-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic issue(logic [VW-1:0] a, logic [VW-1:0] b, logic [VW-1:0] o,
                       logic [15:0] c, string tag);
    @(negedge clk);
    in_valid = 1'b1; ctrl = c; src_a = a; src_b = b; dst_old = o;
    exp_q.push_back(model(a, b, o, c));
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      ctrl = $urandom(); src_a = rand_vec(); src_b = rand_vec(); dst_old = rand_vec();
    end
  endtask

  // Monitor: scoreboard pop and latency/hold checks, sampled after the edge.
  always @(posedge clk) begin : mon
    logic was_valid;
    logic was_rst;
    logic [VW-1:0] e;
    string t;
    was_valid = in_valid;
    was_rst = rst;
    #2;
    if (!was_rst) begin
      check(out_valid === was_valid, "R2", {511'b0, out_valid}, {511'b0, was_valid});
      if (was_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected result", dst_new, '0);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(dst_new === e, t, dst_new, e);
          last_res = e;
        end
      end else begin
        check(dst_new === last_res, "R7", dst_new, last_res);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin : stim
    logic [VW-1:0] acc;
    logic [VW-1:0] regs [N];
    logic [VW-1:0] want;

    // R1: reset state, during reset and on the first cycle after it
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R1 valid", {511'b0, out_valid}, '0);
    check(dst_new === '0, "R1 data", dst_new, '0);
    in_valid = 1'b1;                       // strobe held during reset is ignored
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check(out_valid === 1'b0, "R1 valid after", {511'b0, out_valid}, '0);
    check(dst_new === '0, "R1 data after", dst_new, '0);

    // R3 R4 R5: distinct indices
    issue(rand_vec(), rand_vec(), rand_vec(), {4'd9, 4'd7, 4'd5, 4'd3}, "R3 R4 R5 basic");
    // R8: extreme indices in every field
    issue(rand_vec(), rand_vec(), rand_vec(), {4'd0, 4'd15, 4'd15, 4'd0}, "R8 edges");
    issue(rand_vec(), rand_vec(), rand_vec(), 16'hFFFF, "R8 all 15 with R6");
    issue(rand_vec(), rand_vec(), rand_vec(), 16'h0000, "R8 all 0 with R6");
    // R6: colliding destinations, distinct sources
    issue(rand_vec(), rand_vec(), rand_vec(), {4'd6, 4'd2, 4'd6, 4'd11}, "R6 collide");
    // R7: idle gap, output must hold
    idle(4);
    // R2: back-to-back random operations
    for (int k = 0; k < 40; k++)
      issue(rand_vec(), rand_vec(), rand_vec(), 16'($urandom()), "R2 R3 R4 R5 random");
    idle(2);

    // R9: gather 16 values from 16 vectors in 8 operations
    want = rand_vec();
    for (int k = 0; k < N; k++) begin
      regs[k] = rand_vec();
      regs[k][k*EW +: EW] = want[k*EW +: EW];
    end
    acc = rand_vec();
    for (int j = 0; j < N/2; j++) begin
      logic [15:0] c;
      c = {4'(2*j+1), 4'(2*j+1), 4'(2*j), 4'(2*j)};
      issue(regs[2*j], regs[2*j+1], acc, c, (j == N/2-1) ? "R9 final gather" : "R9 step");
      acc = model(regs[2*j], regs[2*j+1], acc, c);
    end
    idle(3);
    check(last_res === want, "R9 gathered", last_res, want);
    check(exp_q.size() == 0, "R2 drained", '0, '0);
    finish_run();
  end

endmodule